// File: doc/BRIEF.md
# Chip Select Mode Mapper

This block is the chip-select and chip-ID forwarding stage of a memory-module command register. On every rising clock edge it captures the host's two active-low chip selects and its chip-ID bits. It then drives two identical registered output copies, side A and side B, for the two halves of the module's command net.

A two-bit mode field chooses how the captured pins map onto the outputs. Direct dual mode passes two selects and all chip-ID bits straight through. Direct quad mode treats chip-ID bits 0 and 1 as host selects 2 and 3, and presents them on output chip-ID pins 0 and 1, which then serve as output selects 2 and 3. Encoded quad mode builds four rank selects from the two host selects and chip-ID bit 0.

A small state machine holds the active mode. Its states are S_DUAL, S_QDIR and S_QENC. Any transition between two different states is a switch event. In the cycle that follows a switch event, every select output is forced high.

Top module: `csmap_top`

## Requirements
- R1: The mode field maps as follows: 2'b00 selects direct dual (state S_DUAL), 2'b01 selects direct quad (S_QDIR), and 2'b11 selects encoded quad (S_QENC). The reserved value 2'b10 behaves exactly as 2'b00, and a move between 2'b00 and 2'b10 is not a mode change.
- R2: In direct dual mode, output cs_n[0] and cs_n[1] follow host selects 0 and 1, and output cid[2:0] follows host cid[2:0].
- R3: In direct quad mode, output cs_n[1:0] follows host cs_n[1:0], and output cid[0] and cid[1] carry host cid[0] and cid[1] as select 2 and select 3.
- R4: In encoded quad mode, host select 0 drives select 0 when cid[0]=0 and select 1 when cid[0]=1. Host select 1 drives select 2 (output cid[0]) when cid[0]=0 and select 3 (output cid[1]) when cid[0]=1. The unchosen output of each pair stays high.
- R5: In both quad modes, output cid[2] follows host cid[2].
- R6: All outputs are registered. They change only on a rising edge and reflect the inputs sampled at that edge.
- R7: The A and B copies are always equal.
- R8: While rst_n is low, the select outputs are high and the chip-ID outputs are 0.
- R9: On the edge where the sampled mode differs from the current state, the state moves to the new mode and every select output is driven high for one cycle. This covers cs_n[1:0] and, when the new mode is a quad mode, cid[1:0]. In that cycle, cid[2] still follows the host, and in dual mode all cid bits do. Normal mapping resumes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Select-mapping mode field |
| host_cs_n | input | 2 | Host chip selects, active low |
| host_cid | input | CID_W | Host chip-ID bits, bits 1:0 reused as selects in quad modes |
| a_cs_n | output | 2 | Side A selects 0 and 1 |
| a_cid | output | CID_W | Side A chip ID, bits 1:0 are selects 2 and 3 in quad modes |
| b_cs_n | output | 2 | Side B selects 0 and 1 |
| b_cid | output | CID_W | Side B chip ID, same layout as side A |

## Verification
A state register that holds the wrong mode shows up at the ports on the next edge. In that case the pins of a quad mode either pass a raw chip-ID bit or an encoded pair, or they fail to do so, and a single vector with cid[0]=1 and host select 0 low exposes the difference within one cycle. A switch detector that misses an event lets a select go low in the guard cycle. One that fires spuriously, for example on the move between 00 and 10, drives a deselected cycle where a selected one is expected. Both are visible one edge after the mode field moves. A copy register that diverges breaks the A/B equality at once.

// File: rtl/csmap_pkg.sv
package csmap_pkg;

    localparam int CS_W    = 2;
    localparam int NCOPY   = 2;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        S_DUAL = 2'b00,
        S_QDIR = 2'b01,
        S_QENC = 2'b11
    } map_state_e;

    function automatic map_state_e field_to_state(input logic [MODE_W-1:0] fld);
        map_state_e r;
        case (fld)
            2'b01:   r = S_QDIR;
            2'b11:   r = S_QENC;
            default: r = S_DUAL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/csmap_mode_fsm.sv
module csmap_mode_fsm
    import csmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    output map_state_e        state_q,
    output map_state_e        state_nxt,
    output logic              switch_evt
);

    always_comb begin
        state_nxt  = field_to_state(mode_sel);
        switch_evt = (state_nxt != state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_DUAL;
        end else begin
            state_q <= state_nxt;
        end
    end

    // R9
    state_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_evt |=> (state_q == $past(state_nxt)));

    // R1
    reserved_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |=> (state_q == S_DUAL));

endmodule

// File: rtl/csmap_route.sv
module csmap_route
    import csmap_pkg::*;
#(
    parameter int CID_W = 3
) (
    input  map_state_e        mode,
    input  logic              guard,
    input  logic [CS_W-1:0]   host_cs_n,
    input  logic [CID_W-1:0]  host_cid,
    output logic [CS_W-1:0]   cs_d,
    output logic [CID_W-1:0]  cid_d
);

    logic pick_odd;

    always_comb begin
        pick_odd = host_cid[0];
        cs_d     = host_cs_n;
        cid_d    = host_cid;
        unique case (mode)
            S_DUAL: begin
                cs_d  = host_cs_n;
                cid_d = host_cid;
            end
            S_QDIR: begin
                cs_d       = host_cs_n;
                cid_d[1:0] = host_cid[1:0];
            end
            S_QENC: begin
                cs_d[0]  = host_cs_n[0] |  pick_odd;
                cs_d[1]  = host_cs_n[0] | ~pick_odd;
                cid_d[0] = host_cs_n[1] |  pick_odd;
                cid_d[1] = host_cs_n[1] | ~pick_odd;
            end
        endcase
        if (guard) begin
            cs_d = '1;
            if (mode != S_DUAL) begin
                cid_d[1:0] = 2'b11;
            end
        end
    end

    always_comb begin
        if (mode == S_QENC) begin
            // R4
            enc_pair_chk: assert ((cs_d[0] | cs_d[1]) && (cid_d[0] | cid_d[1]));
        end
    end

endmodule

// File: rtl/csmap_copy_reg.sv
module csmap_copy_reg
    import csmap_pkg::*;
#(
    parameter int CID_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CS_W-1:0]   cs_d,
    input  logic [CID_W-1:0]  cid_d,
    output logic [CS_W-1:0]   cs_q,
    output logic [CID_W-1:0]  cid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '1;
            cid_q <= '0;
        end else begin
            cs_q  <= cs_d;
            cid_q <= cid_d;
        end
    end

endmodule

// File: rtl/csmap_top.sv
module csmap_top
    import csmap_pkg::*;
#(
    parameter int CID_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        host_cs_n,
    input  logic [CID_W-1:0]  host_cid,
    output logic [1:0]        a_cs_n,
    output logic [CID_W-1:0]  a_cid,
    output logic [1:0]        b_cs_n,
    output logic [CID_W-1:0]  b_cid
);

    map_state_e         state_q;
    map_state_e         state_nxt;
    logic               switch_evt;
    logic [CS_W-1:0]    cs_d;
    logic [CID_W-1:0]   cid_d;
    logic [CS_W-1:0]    cs_q  [NCOPY];
    logic [CID_W-1:0]   cid_q [NCOPY];

    csmap_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .state_q    (state_q),
        .state_nxt  (state_nxt),
        .switch_evt (switch_evt)
    );

    csmap_route #(.CID_W(CID_W)) u_route (
        .mode      (state_nxt),
        .guard     (switch_evt),
        .host_cs_n (host_cs_n),
        .host_cid  (host_cid),
        .cs_d      (cs_d),
        .cid_d     (cid_d)
    );

    for (genvar g = 0; g < NCOPY; g++) begin : g_copy
        csmap_copy_reg #(.CID_W(CID_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .cs_d  (cs_d),
            .cid_d (cid_d),
            .cs_q  (cs_q[g]),
            .cid_q (cid_q[g])
        );
    end

    assign a_cs_n = cs_q[0];
    assign a_cid  = cid_q[0];
    assign b_cs_n = cs_q[1];
    assign b_cid  = cid_q[1];

    // R7
    copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cs_n == b_cs_n) && (a_cid == b_cid));

    // R2
    dual_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nxt == S_DUAL && !switch_evt) |=>
            (a_cs_n == $past(host_cs_n)) && (a_cid == $past(host_cid)));

    // R4
    enc_sel0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nxt == S_QENC && !switch_evt) |=>
            (a_cs_n[0] == ($past(host_cs_n[0]) | $past(host_cid[0]))));

    // R5
    cid_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nxt != S_DUAL) |=> (a_cid[2] == $past(host_cid[2])));

    // R9
    guard_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_evt |=> (&a_cs_n) && (&b_cs_n));

endmodule

// File: tb/sim_csmap_top.sv
module sim_csmap_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] host_cs_n = 2'b11;
    logic [2:0] host_cid = 3'b000;
    logic [1:0] a_cs_n, b_cs_n;
    logic [2:0] a_cid, b_cid;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [1:0] mdl_mode;
    logic [4:0] prev_exp;
    logic [1:0] last_m;

    always #2 clk = ~clk;

    csmap_top #(.CID_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .host_cs_n(host_cs_n), .host_cid(host_cid),
        .a_cs_n(a_cs_n), .a_cid(a_cid), .b_cs_n(b_cs_n), .b_cid(b_cid)
    );

    function automatic logic [1:0] norm(input logic [1:0] m);
        return (m == 2'b10) ? 2'b00 : m;
    endfunction

    // returns {cid[2:0], cs_n[1:0]}
    function automatic logic [4:0] model(input logic [1:0] nm, input bit chg,
                                         input logic [1:0] cs, input logic [2:0] cid);
        logic [1:0] o_cs;
        logic [2:0] o_cid;
        o_cs  = cs;
        o_cid = cid;
        if (nm == 2'b11) begin
            o_cs[0]  = cid[0] ? 1'b1 : cs[0];
            o_cs[1]  = cid[0] ? cs[0] : 1'b1;
            o_cid[0] = cid[0] ? 1'b1 : cs[1];
            o_cid[1] = cid[0] ? cs[1] : 1'b1;
        end
        if (chg) begin
            o_cs = 2'b11;
            if (nm != 2'b00) o_cid[1:0] = 2'b11;
        end
        return {o_cid, o_cs};
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [1:0] cs, input logic [2:0] cid);
        logic [1:0] nm;
        bit         chg;
        logic [4:0] e;
        string      tag;
        @(negedge clk);
        mode_sel  = m;
        host_cs_n = cs;
        host_cid  = cid;
        #1;
        check("R6 hold-before-edge", {a_cid, a_cs_n}, prev_exp);
        nm  = norm(m);
        chg = (nm != mdl_mode);
        e   = model(nm, chg, cs, cid);
        if (chg)               tag = "R9 guard";
        else if (m == 2'b10)   tag = "R1 reserved";
        else if (nm == 2'b11)  tag = "R4 encoded";
        else if (nm == 2'b01)  tag = "R3 direct-quad";
        else                   tag = "R2 direct-dual";
        @(posedge clk);
        #1;
        check(tag, {a_cid, a_cs_n}, e);
        check("R7 copy", {b_cid, b_cs_n}, {a_cid, a_cs_n});
        if (nm != 2'b00)
            check("R5 cid2", {4'b0000, a_cid[2]}, {4'b0000, cid[2]});
        mdl_mode = nm;
        prev_exp = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4057));
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset A", {a_cid, a_cs_n}, 5'b000_11);
        check("R8 reset B", {b_cid, b_cs_n}, 5'b000_11);
        @(negedge clk);
        rst_n    = 1'b1;
        mdl_mode = 2'b00;
        prev_exp = 5'b000_11;

        // R2 direct dual patterns
        apply(2'b00, 2'b10, 3'b101);
        apply(2'b00, 2'b01, 3'b010);
        // R9 into direct quad with preconditioned selects, R3 after
        apply(2'b01, 2'b00, 3'b011);
        apply(2'b01, 2'b11, 3'b100);
        apply(2'b01, 2'b10, 3'b001);
        // R9/R4 encoded, all select/cid0 combinations
        apply(2'b11, 2'b00, 3'b000);
        for (int i = 0; i < 8; i++) apply(2'b11, i[1:0], {i[2], 1'b0, i[2]});
        // R1 reserved value acts as dual, then 00 is no change
        apply(2'b10, 2'b00, 3'b111);
        apply(2'b10, 2'b01, 3'b110);
        apply(2'b00, 2'b10, 3'b011);
        apply(2'b10, 2'b00, 3'b101);

        last_m = 2'b00;
        for (int k = 0; k < 600; k++) begin
            logic [1:0] m;
            m = last_m;
            if (($urandom % 8) == 0) m = 2'($urandom % 4);
            apply(m, 2'($urandom), 3'($urandom));
            last_m = m;
        end

        // R8 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async reset", {a_cid, a_cs_n}, 5'b000_11);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule